// File: doc/BRIEF.md
# Programmable receive flush timer

This block decides when bytes sitting in a partly filled receive buffer must be pushed to the host even though a full packet has not built up. It counts millisecond ticks since the most recent byte arrived in the buffer. When that count reaches a programmable timeout and the buffer still holds data, it raises a one-cycle flush request. The buffer's own transport logic acts on that request.

The timeout is an 8-bit number of whole milliseconds. A host command writes it through a small configuration port, and it can be rewritten while the block is running. After reset it is 16 ms. A write of zero is treated as 1 ms, so the usable range is 1 to 255 ms.

The counter restarts on every byte written into the buffer and after every flush. It stays at zero for as long as the buffer is empty, so an empty buffer never produces a flush.

Top module: `rx_flush_timer`

## Requirements
- R1: After reset `flush_pulse` is 0 and the timeout setting is 16, so the first flush needs 16 ticks.
- R2: With the buffer non-empty and no byte written, `flush_pulse` goes to 1 in the clock cycle after the cycle in which the T-th `ms_tick` since the last restart was registered, where T is the current timeout.
- R3: After only T-1 ticks since the last restart, no flush is issued.
- R4: A `byte_wr` pulse clears the elapsed count. When `byte_wr` falls in the same cycle as an expiry that would otherwise fire, `byte_wr` takes priority: no flush follows, and a full T ticks are needed again. A tick and a byte in the same cycle leave the count at zero.
- R5: While `buf_nonempty` is 0, ticks are ignored. No flush is issued and the count holds at zero, so after the buffer becomes non-empty a full T ticks are needed.
- R6: `flush_pulse` is high for exactly one cycle and the count restarts with it. A buffer that stays non-empty is flushed again after another T ticks.
- R7: A `cfg_wr` with `cfg_data` in 1..255 sets the timeout to that value from the next cycle on. Without `cfg_wr` the setting is held.
- R8: A `cfg_wr` with `cfg_data` equal to 0 sets the timeout to 1.
- R9: If the timeout is rewritten to a value at or below the ticks already counted, the flush is issued in the second cycle after the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_wr | input | 1 | One-cycle strobe: a byte entered the receive buffer |
| buf_nonempty | input | 1 | Receive buffer holds at least one byte |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| cfg_wr | input | 1 | Write strobe for the timeout setting |
| cfg_data | input | 8 | New timeout in milliseconds (0 treated as 1) |
| flush_pulse | output | 1 | One-cycle request to flush the buffer toward the host |

## Verification
Two events can land in the same cycle: a byte arriving and the timeout expiring. The bench ticks the counter up to exactly the timeout, then drives `byte_wr` during the one cycle in which the expiry is pending. It expects no flush pulse after that cycle, and a complete new timeout before the next flush. A tick and a byte are also driven together, and the bench confirms that the count stays at zero.

// File: rtl/rx_flush_pkg.sv
package rx_flush_pkg;
    localparam int TMO_W = 8;
    localparam logic [TMO_W-1:0] TMO_RESET = TMO_W'(16);

    typedef struct packed {
        logic [TMO_W-1:0] timeout;
    } cfg_state_t;

    typedef struct packed {
        logic [TMO_W-1:0] elapsed;
    } cnt_state_t;

    typedef struct packed {
        logic flush;
    } cmp_state_t;
endpackage

// File: rtl/rx_flush_cfg.sv
module rx_flush_cfg
    import rx_flush_pkg::*;
#(
    parameter int W = TMO_W,
    parameter logic [W-1:0] RST_VAL = TMO_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_data,
    output logic [W-1:0] timeout_q
);
    localparam logic [W-1:0] MIN_VAL = W'(1);

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.timeout = (cfg_data == '0) ? MIN_VAL : cfg_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{timeout: RST_VAL};
        else        st_q <= st_d;
    end

    assign timeout_q = st_q.timeout;

    p_never_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_q != '0);
    p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_data == '0) |=> timeout_q == MIN_VAL);
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_data != '0) |=> timeout_q == $past(cfg_data));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(timeout_q));
endmodule

// File: rtl/rx_flush_cnt.sv
module rx_flush_cnt
    import rx_flush_pkg::*;
#(
    parameter int W = TMO_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ms_tick,
    input  logic         byte_wr,
    input  logic         buf_nonempty,
    input  logic         fire,
    output logic [W-1:0] elapsed_q
);
    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (byte_wr || !buf_nonempty || fire) begin
            st_d.elapsed = '0;
        end else if (ms_tick && st_q.elapsed != '1) begin
            st_d.elapsed = st_q.elapsed + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign elapsed_q = st_q.elapsed;

    p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_nonempty |=> elapsed_q == '0);
    p_byte_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_wr |=> elapsed_q == '0);
endmodule

// File: rtl/rx_flush_cmp.sv
module rx_flush_cmp
    import rx_flush_pkg::*;
#(
    parameter int W = TMO_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] elapsed_q,
    input  logic [W-1:0] timeout_q,
    input  logic         byte_wr,
    input  logic         buf_nonempty,
    output logic         fire,
    output logic         flush_q
);
    cmp_state_t st_d, st_q;

    always_comb begin
        fire = buf_nonempty && !byte_wr && (elapsed_q >= timeout_q);
        st_d.flush = fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flush_q = st_q.flush;

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |=> !flush_q);
    p_empty_no_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_nonempty |=> !flush_q);
    p_byte_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_wr |=> !flush_q);
endmodule

// File: rtl/rx_flush_timer.sv
module rx_flush_timer
    import rx_flush_pkg::*;
#(
    parameter int W = TMO_W,
    parameter logic [W-1:0] RST_VAL = TMO_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         byte_wr,
    input  logic         buf_nonempty,
    input  logic         ms_tick,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_data,
    output logic         flush_pulse
);
    logic [W-1:0] timeout_q;
    logic [W-1:0] elapsed_q;
    logic         fire;

    rx_flush_cfg #(.W(W), .RST_VAL(RST_VAL)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .timeout_q(timeout_q)
    );

    rx_flush_cnt #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .byte_wr(byte_wr),
        .buf_nonempty(buf_nonempty), .fire(fire), .elapsed_q(elapsed_q)
    );

    rx_flush_cmp #(.W(W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .elapsed_q(elapsed_q), .timeout_q(timeout_q),
        .byte_wr(byte_wr), .buf_nonempty(buf_nonempty), .fire(fire),
        .flush_q(flush_pulse)
    );

    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> elapsed_q == '0);
endmodule

// File: tb/rx_flush_timer_test.sv
module rx_flush_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_wr = 1'b0;
    logic       buf_nonempty = 1'b0;
    logic       ms_tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'd0;
    logic       flush_pulse;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rx_flush_timer uut (
        .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .buf_nonempty(buf_nonempty),
        .ms_tick(ms_tick), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .flush_pulse(flush_pulse)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: flush_pulse=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    task automatic byte_in();
        @(negedge clk) byte_wr = 1'b1;
        @(negedge clk) byte_wr = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk) begin cfg_wr = 1'b1; cfg_data = v; end
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    // n ticks; flush must stay low throughout
    task automatic ticks_quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            check(req, flush_pulse, 1'b0);
        end
    endtask

    // after the last tick: low now, high next cycle, low after
    task automatic expect_flush(input string req);
        check(req, flush_pulse, 1'b0);
        @(negedge clk) check(req, flush_pulse, 1'b1);
        @(negedge clk) check(req, flush_pulse, 1'b0);
    endtask

    task automatic t_reset_default();
        check("R1 reset", flush_pulse, 1'b0);
        @(negedge clk) buf_nonempty = 1'b1;
        byte_in();
        ticks_quiet("R3 default 15 ticks", 15);
        tick();
        expect_flush("R1 R2 default 16");
    endtask

    task automatic t_restart();
        ticks_quiet("R6 restart quiet", 15);
        tick();
        expect_flush("R6 second flush");
    endtask

    task automatic t_program(input logic [7:0] t);
        write_cfg(t);
        byte_in();
        ticks_quiet("R3 T-1 ticks", int'(t) - 1);
        tick();
        expect_flush("R2 R7 programmed");
    endtask

    task automatic t_clamp();
        write_cfg(8'd0);
        byte_in();
        tick();
        expect_flush("R8 zero clamps to 1");
    endtask

    task automatic t_empty();
        write_cfg(8'd4);
        @(negedge clk) buf_nonempty = 1'b0;
        ticks_quiet("R5 empty ignores ticks", 20);
        @(negedge clk) buf_nonempty = 1'b1;
        ticks_quiet("R5 count held at zero", 3);
        tick();
        expect_flush("R5 flush after refill");
    endtask

    task automatic t_collision();
        write_cfg(8'd5);
        byte_in();
        ticks_quiet("R4 pre", 5);
        // expiry pending this cycle; byte arrives in it
        byte_wr = 1'b1;
        @(negedge clk) byte_wr = 1'b0;
        check("R4 byte beats expiry", flush_pulse, 1'b0);
        @(negedge clk) check("R4 byte beats expiry", flush_pulse, 1'b0);
        ticks_quiet("R4 full wait again", 4);
        tick();
        expect_flush("R4 flush after new wait");
        // tick and byte in one cycle
        ticks_quiet("R4 tick+byte pre", 3);
        @(negedge clk) begin ms_tick = 1'b1; byte_wr = 1'b1; end
        @(negedge clk) begin ms_tick = 1'b0; byte_wr = 1'b0; end
        ticks_quiet("R4 tick+byte count zero", 4);
        tick();
        expect_flush("R4 tick+byte flush");
    endtask

    task automatic t_lower();
        write_cfg(8'd10);
        byte_in();
        ticks_quiet("R9 pre", 5);
        write_cfg(8'd3);
        expect_flush("R9 lowered below elapsed");
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_default();
        t_restart();
        t_program(8'd7);
        t_program(8'd1);
        t_program(8'd255);
        t_clamp();
        t_empty();
        t_collision();
        t_lower();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule